// File: doc/BRIEF.md
# Absolute-Mode Bus Cycle Sequencer

This block sequences the memory bus of a 16-bit accumulator processor for the absolute addressing mode only. It can run with 8-bit or 16-bit registers, and it has an 8-bit emulation mode. Each clock cycle it makes exactly one byte access. It fetches the opcode and two operand bytes and joins them into a 16-bit effective address. It then runs the data cycles that the instruction class needs: a load-style read of one or two bytes, a store of one or two bytes, a jump, or a subroutine call that pushes its return address onto the stack.

An external arithmetic unit sits beside the sequencer. For loads it receives the assembled operand together with the opcode. For stores it supplies the value to write; that value is requested before any store cycle begins. A completion strobe marks the last bus cycle of every instruction. Any opcode outside the supported set takes one cycle, raises an illegal flag and does nothing else.

Top module: `abs_seq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the block makes a read at the reset address (default 0x8000) with no write. `insn_done`, `alu_valid`, `store_req` and `illegal_op` are low in that cycle unless the byte on `bus_rdata` is an unsupported opcode.
- R2: Every supported instruction starts with three reads at PC, PC+1 and PC+2. These are the opcode, the address low byte and the address high byte. The effective address is {high, low}. The load opcodes are 0x0D, 0x2C, 0x2D, 0x4D, 0x6D, 0xAC, 0xAD, 0xAE, 0xCC, 0xCD, 0xEC and 0xED. A load then reads the effective address. The next opcode fetch is at the byte after the instruction. No cycle is both a read and a write.
- R3: An operand is narrow (8-bit) when emulation is on, or when the governing flag input is 1. The governing flag is `x_narrow` for 0xAC, 0xAE, 0xCC, 0xEC, 0x8C and 0x8E, and `m_narrow` for all other supported opcodes. A wide access adds a second data cycle at the effective address plus one, modulo 2^16. A narrow access omits that cycle.
- R4: In the cycle after the last data read of a load, `alu_valid` is high for one cycle. In that cycle `alu_operand` is {second byte, first byte} for a wide load or {0x00, byte} for a narrow one, and `alu_op` holds the load's opcode.
- R5: The store opcodes are 0x8C, 0x8D, 0x8E and 0x9C. For a store, `store_req` is high during the address-high cycle, and `store_val` is captured at the end of that cycle. The block then writes the low byte at the effective address. For a wide store it next writes the high byte at the effective address plus one.
- R6: Opcode 0x4C makes exactly three reads. The next opcode fetch is at {third byte, second byte}.
- R7: Opcode 0x20 makes its three fetch reads, then a dummy read at the address of its own high operand byte. It then writes that address's high byte and then its low byte to the stack. The next opcode fetch is at {third byte, second byte}.
- R8: Each push writes at the stack address and then decrements the stack pointer (reset value 0x01FF). In native mode the stack address is the full 16-bit pointer and the decrement spans all 16 bits. In emulation mode the address is {0x01, pointer low byte}, and only the low byte decrements, wrapping from 0x00 to 0xFF.
- R9: An opcode outside the supported set takes one cycle. During that cycle `illegal_op` and `insn_done` are high. The next opcode fetch is at PC+1.
- R10: `insn_done` is high in exactly the final bus cycle of every instruction and low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode | input | 1 | Emulation mode: forces narrow operands and keeps the stack in page 1 |
| m_narrow | input | 1 | 1 = accumulator/memory operands are 8-bit |
| x_narrow | input | 1 | 1 = index-register operands are 8-bit |
| bus_rdata | input | 8 | Read data for the current cycle |
| store_val | input | 16 | Value to store, supplied by the arithmetic unit |
| bus_addr | output | 16 | Address of the current access |
| bus_rd | output | 1 | Current cycle is a read |
| bus_wr | output | 1 | Current cycle is a write |
| bus_wdata | output | 8 | Write data for the current cycle |
| alu_op | output | 8 | Opcode of the instruction being performed |
| alu_valid | output | 1 | Load operand is presented |
| alu_operand | output | 16 | Assembled load operand |
| store_req | output | 1 | Request for the store value |
| insn_done | output | 1 | Final bus cycle of an instruction |
| illegal_op | output | 1 | Unsupported opcode fetched this cycle |

## Verification
A corrupted sequencer state shows up on the bus address or strobes within the same cycle. Examples are a skipped or extra data cycle, or a push where a read belongs. The next opcode fetch then lands at the wrong address, so every later instruction is visibly out of step. A wrong width latch or stack pointer shows up within one instruction: as a missing or extra high-byte cycle, or as a push at an unexpected address, including the page-1 wrap in emulation mode. A wrong operand register shows up one cycle after the load completes.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;

   typedef enum logic [3:0] {
      ST_OPC,
      ST_ALO,
      ST_AHI,
      ST_DLO,
      ST_DHI,
      ST_WLO,
      ST_WHI,
      ST_DUMMY,
      ST_PSH_H,
      ST_PSH_L
   } seq_state_e;

   typedef enum logic [2:0] {
      K_NONE,
      K_LOAD,
      K_STORE,
      K_JUMP,
      K_CALL
   } op_kind_e;

   typedef struct packed {
      op_kind_e kind;
      logic     idx_width;
   } op_info_t;

endpackage

// File: rtl/abs_seq_decode.sv
module abs_seq_decode #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0]    opcode,
   output abs_seq_pkg::op_info_t info
);
   import abs_seq_pkg::*;

   localparam int N_LOAD  = 12;
   localparam int N_STORE = 4;
   localparam int N_IDX   = 6;

   localparam logic [BYTE_W-1:0] LOAD_OPS [N_LOAD] = '{
      8'h0D, 8'h2C, 8'h2D, 8'h4D, 8'h6D, 8'hAC,
      8'hAD, 8'hAE, 8'hCC, 8'hCD, 8'hEC, 8'hED
   };
   localparam logic [BYTE_W-1:0] STORE_OPS [N_STORE] = '{
      8'h8C, 8'h8D, 8'h8E, 8'h9C
   };
   localparam logic [BYTE_W-1:0] IDX_OPS [N_IDX] = '{
      8'hAC, 8'hAE, 8'hCC, 8'hEC, 8'h8C, 8'h8E
   };
   localparam logic [BYTE_W-1:0] JUMP_OP = 8'h4C;
   localparam logic [BYTE_W-1:0] CALL_OP = 8'h20;

   always_comb begin
      info.kind      = K_NONE;
      info.idx_width = 1'b0;
      for (int i = 0; i < N_LOAD; i++) begin
         if (opcode == LOAD_OPS[i]) info.kind = K_LOAD;
      end
      for (int i = 0; i < N_STORE; i++) begin
         if (opcode == STORE_OPS[i]) info.kind = K_STORE;
      end
      for (int i = 0; i < N_IDX; i++) begin
         if (opcode == IDX_OPS[i]) info.idx_width = 1'b1;
      end
      if (opcode == JUMP_OP) info.kind = K_JUMP;
      if (opcode == CALL_OP) info.kind = K_CALL;
   end

endmodule

// File: rtl/abs_seq_stack.sv
module abs_seq_stack #(
   parameter int BYTE_W   = 8,
   parameter int WORD_W   = 16,
   parameter int RESET_SP = 'h01FF,
   parameter int EMU_PAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emu_mode,
   input  logic              push_en,
   output logic [WORD_W-1:0] push_addr
);
   localparam logic [BYTE_W-1:0] PAGE    = BYTE_W'(EMU_PAGE);
   localparam logic [WORD_W-1:0] SP_INIT = WORD_W'(RESET_SP);

   logic [WORD_W-1:0] sp_q;
   logic [BYTE_W-1:0] low_dec;

   assign low_dec   = sp_q[BYTE_W-1:0] - {{(BYTE_W-1){1'b0}}, 1'b1};
   assign push_addr = emu_mode ? {PAGE, sp_q[BYTE_W-1:0]} : sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_INIT;
      end else if (push_en) begin
         if (emu_mode) sp_q <= {PAGE, low_dec};
         else          sp_q <= sp_q - {{(WORD_W-1){1'b0}}, 1'b1};
      end
   end

endmodule

// File: rtl/abs_seq_top.sv
module abs_seq_top #(
   parameter int BYTE_W   = 8,
   parameter int RESET_PC = 'h8000,
   parameter int RESET_SP = 'h01FF,
   parameter int EMU_PAGE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                emu_mode,
   input  logic                m_narrow,
   input  logic                x_narrow,
   input  logic [BYTE_W-1:0]   bus_rdata,
   input  logic [2*BYTE_W-1:0] store_val,
   output logic [2*BYTE_W-1:0] bus_addr,
   output logic                bus_rd,
   output logic                bus_wr,
   output logic [BYTE_W-1:0]   bus_wdata,
   output logic [BYTE_W-1:0]   alu_op,
   output logic                alu_valid,
   output logic [2*BYTE_W-1:0] alu_operand,
   output logic                store_req,
   output logic                insn_done,
   output logic                illegal_op
);
   import abs_seq_pkg::*;

   localparam int WORD_W = 2 * BYTE_W;
   localparam logic [WORD_W-1:0] PC_INIT = WORD_W'(RESET_PC);
   localparam logic [WORD_W-1:0] ONE     = {{(WORD_W-1){1'b0}}, 1'b1};

   if (BYTE_W != 8) begin : g_byte_chk
      $error("abs_seq_top: BYTE_W must be 8, opcode constants are byte-wide");
   end
   if (RESET_PC < 0 || RESET_PC >= (1 << WORD_W)) begin : g_pc_chk
      $error("abs_seq_top: RESET_PC does not fit the address width");
   end
   if (RESET_SP < 0 || RESET_SP >= (1 << WORD_W)) begin : g_sp_chk
      $error("abs_seq_top: RESET_SP does not fit the address width");
   end
   if (EMU_PAGE < 0 || EMU_PAGE >= (1 << BYTE_W)) begin : g_page_chk
      $error("abs_seq_top: EMU_PAGE does not fit one byte");
   end

   seq_state_e        state_q;
   op_kind_e          kind_q;
   logic              wide_q;
   logic [BYTE_W-1:0] opc_q;
   logic [BYTE_W-1:0] adl_q;
   logic [BYTE_W-1:0] dlo_q;
   logic [WORD_W-1:0] pc_q;
   logic [WORD_W-1:0] ea_q;
   logic [WORD_W-1:0] st_q;
   logic [WORD_W-1:0] operand_q;
   logic              valid_q;

   op_info_t          info_now;
   logic              wide_now;
   logic [WORD_W-1:0] pc_inc;
   logic [WORD_W-1:0] ea_inc;
   logic [WORD_W-1:0] push_addr;
   logic              push_en;

   abs_seq_decode #(.BYTE_W(BYTE_W)) u_dec (
      .opcode (bus_rdata),
      .info   (info_now)
   );

   abs_seq_stack #(
      .BYTE_W   (BYTE_W),
      .WORD_W   (WORD_W),
      .RESET_SP (RESET_SP),
      .EMU_PAGE (EMU_PAGE)
   ) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .emu_mode  (emu_mode),
      .push_en   (push_en),
      .push_addr (push_addr)
   );

   assign pc_inc   = pc_q + ONE;
   assign ea_inc   = ea_q + ONE;
   assign wide_now = !emu_mode && (info_now.idx_width ? !x_narrow : !m_narrow);
   assign push_en  = (state_q == ST_PSH_H) || (state_q == ST_PSH_L);

   assign alu_op      = opc_q;
   assign alu_valid   = valid_q;
   assign alu_operand = operand_q;
   assign store_req   = (state_q == ST_AHI) && (kind_q == K_STORE);
   assign illegal_op  = (state_q == ST_OPC) && (info_now.kind == K_NONE);

   // Bus drive per state
   always_comb begin
      bus_addr  = pc_q;
      bus_rd    = 1'b1;
      bus_wr    = 1'b0;
      bus_wdata = '0;
      insn_done = 1'b0;
      unique case (state_q)
         ST_OPC:   insn_done = (info_now.kind == K_NONE);
         ST_ALO:   ;
         ST_AHI:   insn_done = (kind_q == K_JUMP);
         ST_DLO: begin
            bus_addr  = ea_q;
            insn_done = !wide_q;
         end
         ST_DHI: begin
            bus_addr  = ea_inc;
            insn_done = 1'b1;
         end
         ST_WLO: begin
            bus_addr  = ea_q;
            bus_rd    = 1'b0;
            bus_wr    = 1'b1;
            bus_wdata = st_q[BYTE_W-1:0];
            insn_done = !wide_q;
         end
         ST_WHI: begin
            bus_addr  = ea_inc;
            bus_rd    = 1'b0;
            bus_wr    = 1'b1;
            bus_wdata = st_q[WORD_W-1:BYTE_W];
            insn_done = 1'b1;
         end
         ST_DUMMY: ;
         ST_PSH_H: begin
            bus_addr  = push_addr;
            bus_rd    = 1'b0;
            bus_wr    = 1'b1;
            bus_wdata = pc_q[WORD_W-1:BYTE_W];
         end
         ST_PSH_L: begin
            bus_addr  = push_addr;
            bus_rd    = 1'b0;
            bus_wr    = 1'b1;
            bus_wdata = pc_q[BYTE_W-1:0];
            insn_done = 1'b1;
         end
         default: ;
      endcase
   end

   // Sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OPC;
         kind_q    <= K_NONE;
         wide_q    <= 1'b0;
         opc_q     <= '0;
         adl_q     <= '0;
         dlo_q     <= '0;
         pc_q      <= PC_INIT;
         ea_q      <= '0;
         st_q      <= '0;
         operand_q <= '0;
         valid_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state_q)
            ST_OPC: begin
               opc_q   <= bus_rdata;
               kind_q  <= info_now.kind;
               wide_q  <= wide_now;
               pc_q    <= pc_inc;
               state_q <= (info_now.kind == K_NONE) ? ST_OPC : ST_ALO;
            end
            ST_ALO: begin
               adl_q   <= bus_rdata;
               pc_q    <= pc_inc;
               state_q <= ST_AHI;
            end
            ST_AHI: begin
               ea_q <= {bus_rdata, adl_q};
               unique case (kind_q)
                  K_JUMP: begin
                     pc_q    <= {bus_rdata, adl_q};
                     state_q <= ST_OPC;
                  end
                  K_CALL:  state_q <= ST_DUMMY;
                  K_STORE: begin
                     pc_q    <= pc_inc;
                     st_q    <= store_val;
                     state_q <= ST_WLO;
                  end
                  default: begin
                     pc_q    <= pc_inc;
                     state_q <= ST_DLO;
                  end
               endcase
            end
            ST_DLO: begin
               dlo_q <= bus_rdata;
               if (wide_q) begin
                  state_q <= ST_DHI;
               end else begin
                  operand_q <= {{BYTE_W{1'b0}}, bus_rdata};
                  valid_q   <= 1'b1;
                  state_q   <= ST_OPC;
               end
            end
            ST_DHI: begin
               operand_q <= {bus_rdata, dlo_q};
               valid_q   <= 1'b1;
               state_q   <= ST_OPC;
            end
            ST_WLO:   state_q <= wide_q ? ST_WHI : ST_OPC;
            ST_WHI:   state_q <= ST_OPC;
            ST_DUMMY: state_q <= ST_PSH_H;
            ST_PSH_H: state_q <= ST_PSH_L;
            ST_PSH_L: begin
               pc_q    <= ea_q;
               state_q <= ST_OPC;
            end
            default:  state_q <= ST_OPC;
         endcase
      end
   end

endmodule

// File: rtl/abs_seq_chk.sv
module abs_seq_chk #(
   parameter int BYTE_W   = 8,
   parameter int WORD_W   = 16,
   parameter int EMU_PAGE = 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input abs_seq_pkg::seq_state_e state_q,
   input logic [WORD_W-1:0]       bus_addr,
   input logic                    bus_rd,
   input logic                    bus_wr,
   input logic                    emu_mode,
   input logic                    insn_done,
   input logic                    alu_valid,
   input logic                    illegal_op
);
   import abs_seq_pkg::*;

   // R2
   one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R3
   dhi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DHI) |-> (bus_addr == WORD_W'($past(bus_addr) + 1'b1)));

   // R5
   whi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WHI) |-> (bus_addr == WORD_W'($past(bus_addr) + 1'b1) && bus_wr));

   // R8
   push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PSH_L) |->
         (bus_addr[BYTE_W-1:0] == BYTE_W'($past(bus_addr[BYTE_W-1:0]) - 1'b1)));

   // R8
   emu_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_PSH_H || state_q == ST_PSH_L) && emu_mode) |->
         (bus_addr[WORD_W-1:BYTE_W] == BYTE_W'(EMU_PAGE)));

   // R10
   done_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      insn_done |=> (bus_rd && state_q == ST_OPC));

   // R4
   valid_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_valid |-> ($past(insn_done) && $past(bus_rd)));

   // R9
   illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> insn_done);

endmodule

bind abs_seq_top abs_seq_chk #(
   .BYTE_W   (BYTE_W),
   .WORD_W   (WORD_W),
   .EMU_PAGE (EMU_PAGE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .state_q    (state_q),
   .bus_addr   (bus_addr),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .emu_mode   (emu_mode),
   .insn_done  (insn_done),
   .alu_valid  (alu_valid),
   .illegal_op (illegal_op)
);

// File: tb/abs_seq_top_test.sv
`timescale 1ns/1ps
module abs_seq_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        emu_mode = 1'b0;
   logic        m_narrow = 1'b0;
   logic        x_narrow = 1'b0;
   logic [7:0]  bus_rdata = 8'hAD;
   logic [15:0] store_val = 16'h0000;
   logic [15:0] bus_addr;
   logic        bus_rd, bus_wr;
   logic [7:0]  bus_wdata;
   logic [7:0]  alu_op;
   logic        alu_valid;
   logic [15:0] alu_operand;
   logic        store_req, insn_done, illegal_op;

   always #2 clk = ~clk;

   abs_seq_top uut (
      .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .m_narrow(m_narrow),
      .x_narrow(x_narrow), .bus_rdata(bus_rdata), .store_val(store_val),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .alu_op(alu_op), .alu_valid(alu_valid),
      .alu_operand(alu_operand), .store_req(store_req),
      .insn_done(insn_done), .illegal_op(illegal_op)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [15:0] pc_m = 16'h8000;
   logic [15:0] sp_m = 16'h01FF;
   bit          pend_v = 0;
   logic [7:0]  pend_op;
   logic [15:0] pend_val;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit is_load(input logic [7:0] op);
      case (op)
         8'h0D, 8'h2C, 8'h2D, 8'h4D, 8'h6D, 8'hAC,
         8'hAD, 8'hAE, 8'hCC, 8'hCD, 8'hEC, 8'hED: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic bit is_store(input logic [7:0] op);
      return op == 8'h8C || op == 8'h8D || op == 8'h8E || op == 8'h9C;
   endfunction

   function automatic bit is_idx(input logic [7:0] op);
      case (op)
         8'hAC, 8'hAE, 8'hCC, 8'hEC, 8'h8C, 8'h8E: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic [15:0] stk_addr();
      return emu_mode ? {8'h01, sp_m[7:0]} : sp_m;
   endfunction

   task automatic stk_dec();
      if (emu_mode) sp_m = {8'h01, 8'(sp_m[7:0] - 8'd1)};
      else          sp_m = 16'(sp_m - 16'd1);
   endtask

   // One bus cycle: entered just after a falling edge, leaves at the next one.
   task automatic bus_step(input logic [7:0] rv, input bit e_rd, input bit e_wr,
                           input logic [15:0] e_addr, input logic [7:0] e_wd,
                           input bit e_done, input bit e_ill, input bit e_str,
                           input string tag);
      bus_rdata = rv;
      #1;
      chk(tag, "bus_addr", int'(bus_addr), int'(e_addr));
      chk(tag, "bus_rd", int'(bus_rd), int'(e_rd));
      chk(tag, "bus_wr", int'(bus_wr), int'(e_wr));
      if (e_wr) chk(tag, "bus_wdata", int'(bus_wdata), int'(e_wd));
      chk("R10", "insn_done", int'(insn_done), int'(e_done));
      chk("R9", "illegal_op", int'(illegal_op), int'(e_ill));
      chk("R5", "store_req", int'(store_req), int'(e_str));
      chk("R4", "alu_valid", int'(alu_valid), int'(pend_v));
      if (pend_v) begin
         chk("R4", "alu_operand", int'(alu_operand), int'(pend_val));
         chk("R4", "alu_op", int'(alu_op), int'(pend_op));
      end
      pend_v = 0;
      @(negedge clk);
   endtask

   task automatic run(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                      input logic [7:0] d0, input logic [7:0] d1, input logic [15:0] sv);
      bit ld, st, jmp, jsr, ill, wide;
      logic [15:0] ea;
      ld   = is_load(op);
      st   = is_store(op);
      jmp  = (op == 8'h4C);
      jsr  = (op == 8'h20);
      ill  = !(ld || st || jmp || jsr);
      wide = !emu_mode && (is_idx(op) ? !x_narrow : !m_narrow);
      ea   = {hi, lo};
      store_val = sv;
      bus_step(op, 1, 0, pc_m, 8'h00, ill, ill, 0, ill ? "R9" : "R2");
      pc_m = 16'(pc_m + 16'd1);
      if (ill) return;
      bus_step(lo, 1, 0, pc_m, 8'h00, 0, 0, 0, "R2");
      pc_m = 16'(pc_m + 16'd1);
      bus_step(hi, 1, 0, pc_m, 8'h00, jmp, 0, st, jmp ? "R6" : "R2");
      if (jmp) begin
         pc_m = ea;
      end else if (jsr) begin
         bus_step(8'h5A, 1, 0, pc_m, 8'h00, 0, 0, 0, "R7");
         bus_step(8'h00, 0, 1, stk_addr(), pc_m[15:8], 0, 0, 0, "R8");
         stk_dec();
         bus_step(8'h00, 0, 1, stk_addr(), pc_m[7:0], 1, 0, 0, "R7");
         stk_dec();
         pc_m = ea;
      end else if (ld) begin
         pc_m = 16'(pc_m + 16'd1);
         bus_step(d0, 1, 0, ea, 8'h00, !wide, 0, 0, "R2");
         if (wide) bus_step(d1, 1, 0, 16'(ea + 16'd1), 8'h00, 1, 0, 0, "R3");
         pend_v   = 1;
         pend_op  = op;
         pend_val = wide ? {d1, d0} : {8'h00, d0};
      end else begin
         pc_m = 16'(pc_m + 16'd1);
         bus_step(8'h00, 0, 1, ea, sv[7:0], !wide, 0, 0, "R5");
         if (wide) bus_step(8'h00, 0, 1, 16'(ea + 16'd1), sv[15:8], 1, 0, 0, "R3");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "reset bus_addr", int'(bus_addr), 16'h8000);
      chk("R1", "reset bus_rd", int'(bus_rd), 1);
      chk("R1", "reset bus_wr", int'(bus_wr), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      chk("R1", "first bus_addr", int'(bus_addr), 16'h8000);
      chk("R1", "first bus_rd", int'(bus_rd), 1);
      chk("R1", "first bus_wr", int'(bus_wr), 0);
      chk("R1", "first insn_done", int'(insn_done), 0);
      chk("R1", "first alu_valid", int'(alu_valid), 0);
      chk("R1", "first store_req", int'(store_req), 0);
      #0.5;
      // Sweep all opcodes under all mode combinations
      for (int mode = 0; mode < 8; mode++) begin
         emu_mode = mode[2];
         m_narrow = mode[1];
         x_narrow = mode[0];
         for (int op = 0; op < 256; op++) begin
            run(8'(op), 8'(op * 7 + mode), 8'(op ^ (mode << 5)),
                8'(~op), 8'(op + mode * 3), {8'(op), 8'(~(op * 7 + mode))});
         end
      end
      // Address wrap at the top of memory, wide load and store
      emu_mode = 0; m_narrow = 0; x_narrow = 0;
      run(8'hAD, 8'hFF, 8'hFF, 8'h34, 8'h12, 16'h0000);
      run(8'h8D, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'hBEEF);
      run(8'hAE, 8'hFF, 8'hFF, 8'hC3, 8'h3C, 16'h0000);
      x_narrow = 1;
      run(8'hAE, 8'h00, 8'h20, 8'h77, 8'h88, 16'h0000);
      run(8'h8E, 8'h00, 8'h20, 8'h00, 8'h00, 16'hA55A);
      run(8'hAD, 8'h00, 8'h20, 8'h66, 8'h99, 16'h0000);
      // Emulation: push low byte wraps within page 1
      emu_mode = 1;
      for (int i = 0; i < 140; i++) run(8'h20, 8'(i), 8'h40, 8'h00, 8'h00, 16'h0000);
      // Native: full 16-bit descent across a page boundary
      emu_mode = 0;
      for (int i = 0; i < 300; i++) run(8'h20, 8'(i * 3), 8'h50, 8'h00, 8'h00, 16'h0000);
      run(8'hEA, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000);
      run(8'h4C, 8'h34, 8'h12, 8'h00, 8'h00, 16'h0000);
      run(8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R10 watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule